// File: doc/BRIEF.md
# Datapath Self-Test Controller

This block checks the digital part of a two-channel sampled-data path without needing a live input signal. A start pulse begins a test. From then on, each selected channel's converter sample is swapped for a pseudorandom word at the point where digital processing starts. Every downstream stage therefore sees a known stimulus. The words coming back from the end of that datapath are folded into one 16-bit signature register per channel. After a fixed run of 512 valid sample cycles the test stops by itself and raises a done flag. The reported signature is then held in two byte-wide registers that software reads.

The outputs toward the datapath stay connected the whole time, so the stimulus can be watched as it flows. A configuration byte chooses whether each new test replays the stimulus from its seed or picks up where the previous test stopped. A channel that is not selected keeps passing its converter samples through untouched.

Top module: `dpath_selftest`

## Requirements
- R1: While a test is active, a selected channel A drives `toDpA` with the stimulus word {s[8:0], s[8:2]}, and a selected channel B drives `toDpB` with the bitwise inverse of that word. Here s is the generator state. An unselected channel, and both channels when no test is active, pass `convA`/`convB` straight through.
- R2: The stimulus generator is a 9-bit shift register with feedback s[8]^s[4] shifted into bit 0 (polynomial x^9+x^5+1). It holds all ones after reset and advances once per cycle in which a test is active and `sampleValid` is high.
- R3: A test ends after exactly 512 valid cycles. `bistDone` is low throughout the run and goes high in the cycle after the 512th valid cycle.
- R4: Each channel's 16-bit signature is cleared when a test is accepted. On every valid cycle of the run it is updated to (m<<1) ^ (m[15] ? 16'h1021 : 0) ^ ret, where ret is that channel's `retA`/`retB` in the same cycle.
- R5: The reported signature appears at address 0x24 (bits 7:0) and 0x25 (bits 15:8). Writes to these addresses are ignored.
- R6: With `chanSel` = 2'b01 (A only) or 2'b11 (both), the reported signature is channel A's. With 2'b10 (B only) it is channel B's. `chanSel` is sampled with the accepted start.
- R7: `bistDone` stays high until the next accepted start, which clears it. The reported signature does not change while it is high.
- R8: The byte at address 0x0E is a read/write configuration register. Bit 2 = 1 makes an accepted start reload the generator with all ones. Bit 2 = 0 lets the generator continue from its current state.
- R9: A start pulse during an active test is ignored, together with any change of `chanSel`. The run, its length and its signature are unaffected.
- R10: A start pulse with `chanSel` = 2'b00 is ignored. No test begins and `bistDone` and the signature keep their values.
- R11: After reset, `bistDone` is 0, addresses 0x24, 0x25 and 0x0E read 0, and both channels pass through. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on address) |
| startPulse | input | 1 | Test start request |
| chanSel | input | 2 | Channel select, bit 0 = A, bit 1 = B |
| sampleValid | input | 1 | Marks a valid sample cycle |
| convA | input | 16 | Converter sample, channel A |
| convB | input | 16 | Converter sample, channel B |
| toDpA | output | 16 | Sample into datapath, channel A |
| toDpB | output | 16 | Sample into datapath, channel B |
| retA | input | 16 | Datapath result, channel A |
| retB | input | 16 | Datapath result, channel B |
| bistDone | output | 1 | Test finished flag |

## Verification
The assertions assume a particular timing for the return path. `retA` and `retB` must belong to the same cycle as the `toDpA`/`toDpB` words they came from, and `sampleValid` must qualify both directions together. The bench meets this by modelling the downstream datapath as combinational functions of the outputs. It changes all inputs only on falling edges and pulses start for a single cycle. Start requests with an empty selection and requests made in the middle of a run are deliberate parts of the stimulus, so the checks that those requests are ignored actually get exercised.

// File: rtl/dpath_selftest_pkg.sv
`timescale 1ns/1ps
package dpath_selftest_pkg;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic start;     // test accepted this cycle
    logic step;      // valid cycle of an active run
    logic finish;    // last valid cycle of the run
    logic injA;      // replace channel A samples
    logic injB;      // replace channel B samples
    logic sigFromB;  // report channel B signature
  } bistStrb_t;

endpackage

// File: rtl/dpath_selftest_ctrl.sv
`timescale 1ns/1ps
module dpath_selftest_ctrl
  import dpath_selftest_pkg::*;
#(
  parameter int RUN_LEN = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] chanSel,
  input  logic       sampleValid,
  output bistStrb_t  strb,
  output logic       doneFlag
);

  localparam int CNT_W = $clog2(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

  logic             runningQ;
  logic             doneQ;
  logic [CNT_W-1:0] cntQ;
  logic [1:0]       chanQ;
  logic             startAcc;
  logic             stepNow;
  logic             finishNow;

  assign startAcc  = startPulse && !runningQ && (chanSel != 2'b00);
  assign stepNow   = runningQ && sampleValid;
  assign finishNow = stepNow && (cntQ == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runningQ <= 1'b0;
      doneQ    <= 1'b0;
      cntQ     <= '0;
      chanQ    <= 2'b00;
    end else if (startAcc) begin
      runningQ <= 1'b1;
      doneQ    <= 1'b0;
      cntQ     <= '0;
      chanQ    <= chanSel;
    end else if (finishNow) begin
      runningQ <= 1'b0;
      doneQ    <= 1'b1;
      cntQ     <= '0;
    end else if (stepNow) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_comb begin
    strb.start    = startAcc;
    strb.step     = stepNow;
    strb.finish   = finishNow;
    strb.injA     = runningQ && chanQ[0];
    strb.injB     = runningQ && chanQ[1];
    strb.sigFromB = !chanQ[0];
  end

  assign doneFlag = doneQ;

  // R3: done only rises directly out of an active run
  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(runningQ));

  // R7: done holds until a start request arrives
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !startPulse) |=> doneQ);

  // R9: a start during a run that is not ending keeps the run and its selection
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (runningQ && startPulse && !(sampleValid && cntQ == LAST_CNT))
      |=> (runningQ && $stable(chanQ)));

  // R10: an empty selection never starts a test
  a_r10_empty_sel_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!runningQ && startPulse && chanSel == 2'b00) |=> !runningQ);

endmodule

// File: rtl/dpath_selftest_dp.sv
`timescale 1ns/1ps
module dpath_selftest_dp
  import dpath_selftest_pkg::*;
#(
  parameter int                SAMPLE_W    = 16,
  parameter int                LFSR_W      = 9,
  parameter int                TAP_LO      = 5,
  parameter int                ADDR_W      = 8,
  parameter int                REG_W       = 8,
  parameter logic [SAMPLE_W-1:0] MISR_POLY = 16'h1021,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h0E,
  parameter logic [ADDR_W-1:0] SIG_LO_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SIG_HI_ADDR = 8'h25,
  parameter int                RESTART_BIT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  bistStrb_t           strb,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [SAMPLE_W-1:0] convA,
  input  logic [SAMPLE_W-1:0] convB,
  output logic [SAMPLE_W-1:0] toDpA,
  output logic [SAMPLE_W-1:0] toDpB,
  input  logic [SAMPLE_W-1:0] retA,
  input  logic [SAMPLE_W-1:0] retB
);

  localparam logic [LFSR_W-1:0] SEED = '1;

  logic [LFSR_W-1:0]   lfsrQ;
  logic                feedback;
  logic [SAMPLE_W-1:0] stim;
  logic [SAMPLE_W-1:0] misrAQ, misrBQ;
  logic [SAMPLE_W-1:0] misrANext, misrBNext;
  logic [SAMPLE_W-1:0] sigQ;
  logic [REG_W-1:0]    cfgQ;

  function automatic logic [SAMPLE_W-1:0] misrStep(
    input logic [SAMPLE_W-1:0] m,
    input logic [SAMPLE_W-1:0] d
  );
    misrStep = {m[SAMPLE_W-2:0], 1'b0} ^ (m[SAMPLE_W-1] ? MISR_POLY : '0) ^ d;
  endfunction

  // stimulus generator
  assign feedback = lfsrQ[LFSR_W-1] ^ lfsrQ[TAP_LO-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= SEED;
    end else if (strb.start && cfgQ[RESTART_BIT]) begin
      lfsrQ <= SEED;
    end else if (strb.step) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], feedback};
    end
  end

  // widen the generator state to the sample width, wrapping from the MSB
  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_widen
    assign stim[SAMPLE_W-1-i] = lfsrQ[LFSR_W-1-(i % LFSR_W)];
  end

  // injection at the datapath entry
  assign toDpA = strb.injA ? stim  : convA;
  assign toDpB = strb.injB ? ~stim : convB;

  // signature compression
  assign misrANext = misrStep(misrAQ, retA);
  assign misrBNext = misrStep(misrBQ, retB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misrAQ <= '0;
      misrBQ <= '0;
    end else if (strb.start) begin
      misrAQ <= '0;
      misrBQ <= '0;
    end else if (strb.step) begin
      misrAQ <= misrANext;
      misrBQ <= misrBNext;
    end
  end

  // result placement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigQ <= '0;
    end else if (strb.finish) begin
      sigQ <= strb.sigFromB ? misrBNext : misrANext;
    end
  end

  // configuration byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (regWrEn && regAddr == CFG_ADDR) begin
      cfgQ <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == CFG_ADDR)    regRdData = cfgQ;
    if (regAddr == SIG_LO_ADDR) regRdData = sigQ[REG_W-1:0];
    if (regAddr == SIG_HI_ADDR) regRdData = sigQ[2*REG_W-1:REG_W];
  end

  // R2: the generator never locks up in the all-zero state
  a_r2_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  // R5: register writes never disturb the reported signature
  a_r5_sig_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !strb.finish) |=> $stable(sigQ));

  // R4: compression registers only move on valid run cycles or a start
  a_r4_misr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.start) |=> ($stable(misrAQ) && $stable(misrBQ)));

endmodule

// File: rtl/dpath_selftest.sv
`timescale 1ns/1ps
module dpath_selftest
  import dpath_selftest_pkg::*;
#(
  parameter int                SAMPLE_W    = 16,
  parameter int                LFSR_W      = 9,
  parameter int                TAP_LO      = 5,
  parameter int                RUN_LEN     = 512,
  parameter int                ADDR_W      = 8,
  parameter int                REG_W       = 8,
  parameter logic [SAMPLE_W-1:0] MISR_POLY = 16'h1021,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h0E,
  parameter logic [ADDR_W-1:0] SIG_LO_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SIG_HI_ADDR = 8'h25,
  parameter int                RESTART_BIT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                startPulse,
  input  logic [1:0]          chanSel,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] convA,
  input  logic [SAMPLE_W-1:0] convB,
  output logic [SAMPLE_W-1:0] toDpA,
  output logic [SAMPLE_W-1:0] toDpB,
  input  logic [SAMPLE_W-1:0] retA,
  input  logic [SAMPLE_W-1:0] retB,
  output logic                bistDone
);

  bistStrb_t strb;

  dpath_selftest_ctrl #(
    .RUN_LEN (RUN_LEN)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .chanSel     (chanSel),
    .sampleValid (sampleValid),
    .strb        (strb),
    .doneFlag    (bistDone)
  );

  dpath_selftest_dp #(
    .SAMPLE_W    (SAMPLE_W),
    .LFSR_W      (LFSR_W),
    .TAP_LO      (TAP_LO),
    .ADDR_W      (ADDR_W),
    .REG_W       (REG_W),
    .MISR_POLY   (MISR_POLY),
    .CFG_ADDR    (CFG_ADDR),
    .SIG_LO_ADDR (SIG_LO_ADDR),
    .SIG_HI_ADDR (SIG_HI_ADDR),
    .RESTART_BIT (RESTART_BIT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .convA     (convA),
    .convB     (convB),
    .toDpA     (toDpA),
    .toDpB     (toDpB),
    .retA      (retA),
    .retB      (retB)
  );

  // R1: with no test running and done set, both channels pass through
  a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rstN)
    bistDone |-> (toDpA == convA && toDpB == convB));

endmodule

// File: tb/dpath_selftest_tb_top.sv
`timescale 1ns/1ps
module dpath_selftest_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic        startPulse = 1'b0;
  logic [1:0]  chanSel = 2'b00;
  logic        sampleValid = 1'b0;
  logic [15:0] convA = 16'h0;
  logic [15:0] convB = 16'h0;
  logic [15:0] toDpA, toDpB, retA, retB;
  logic        bistDone;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct { logic [15:0] a; logic [15:0] b; string tag; } expItem_t;
  expItem_t expQ[$];

  // bench model state
  logic [8:0]  mLfsr = 9'h1FF;
  logic [15:0] mSigA = 16'h0, mSigB = 16'h0, mReported = 16'h0;
  logic [7:0]  mCfg = 8'h00;

  always #4 clk = ~clk;

  // downstream datapath stand-in: combinational per channel
  assign retA = toDpA ^ 16'hA5A5;
  assign retB = {toDpB[7:0], toDpB[15:8]};

  dpath_selftest dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .startPulse(startPulse),
    .chanSel(chanSel), .sampleValid(sampleValid), .convA(convA), .convB(convB),
    .toDpA(toDpA), .toDpB(toDpB), .retA(retA), .retB(retB), .bistDone(bistDone)
  );

  function automatic logic [15:0] sigStep(input logic [15:0] m, input logic [15:0] d);
    return {m[14:0], 1'b0} ^ (m[15] ? 16'h1021 : 16'h0000) ^ d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected output pair per cycle while items are queued
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(toDpA == e.a && toDpB == e.b, e.tag, {toDpA, toDpB}, {e.a, e.b});
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 8'h0E) mCfg = d;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdData;
  endtask

  task automatic checkSig(input string tag);
    logic [7:0] lo, hi;
    regRead(8'h24, lo);
    regRead(8'h25, hi);
    check({hi, lo} == mReported, tag, {16'h0, hi, lo}, {16'h0, mReported});
  endtask

  task automatic idleCycles(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      expItem_t e;
      @(negedge clk);
      convA = 16'h5A00 + 16'(k); convB = 16'h0F0F ^ 16'(k * 5);
      e.a = convA; e.b = convB; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  // driver: runs one full test and queues every expected datapath word
  task automatic runTest(input logic [1:0] sel, input bit gapMode, input bit midStart, input string tag);
    expItem_t e;
    int counted = 0;
    int i = 0;
    @(negedge clk);
    startPulse = 1'b1; chanSel = sel; sampleValid = 1'b1;
    convA = 16'h1111; convB = 16'h2222;
    e.a = convA; e.b = convB; e.tag = {tag, " R1 start-cycle passthrough"};
    expQ.push_back(e);
    if (mCfg[2]) mLfsr = 9'h1FF;
    mSigA = 16'h0; mSigB = 16'h0;
    @(negedge clk);
    while (counted < 512) begin
      logic [15:0] stim;
      sampleValid = gapMode ? ((i % 3) != 2) : 1'b1;
      convA = 16'h3000 + 16'(i); convB = 16'hC000 ^ 16'(i * 7);
      startPulse = midStart && (i == 100);   // R9 request during run
      if (midStart && i == 100) chanSel = ~sel;
      stim = {mLfsr, mLfsr[8:2]};
      e.a = sel[0] ? stim : convA;
      e.b = sel[1] ? ~stim : convB;
      e.tag = {tag, " R1 R2 stimulus stream"};
      expQ.push_back(e);
      if (sampleValid) begin
        mSigA = sigStep(mSigA, e.a ^ 16'hA5A5);
        mSigB = sigStep(mSigB, {e.b[7:0], e.b[15:8]});
        mLfsr = {mLfsr[7:0], mLfsr[8] ^ mLfsr[4]};
        counted++;
      end
      if (i == 0) begin
        #2 check(bistDone == 1'b0, {tag, " R7 done cleared by start"}, 32'(bistDone), 32'd0);
      end
      if (counted == 512) begin
        #2 check(bistDone == 1'b0, {tag, " R3 done low in final cycle"}, 32'(bistDone), 32'd0);
      end
      @(negedge clk);
      i++;
    end
    sampleValid = 1'b0; startPulse = 1'b0; chanSel = 2'b00;
    #2 check(bistDone == 1'b1, {tag, " R3 done after 512 valid cycles"}, 32'(bistDone), 32'd1);
    mReported = (sel == 2'b10) ? mSigB : mSigA;
    checkSig({tag, " R4 R6 signature"});
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    #2 check(bistDone == 1'b0, "R11 done after reset", 32'(bistDone), 32'd0);
    regRead(8'h24, rd); check(rd == 8'h00, "R11 sig lo after reset", 32'(rd), 32'd0);
    regRead(8'h25, rd); check(rd == 8'h00, "R11 sig hi after reset", 32'(rd), 32'd0);
    regRead(8'h0E, rd); check(rd == 8'h00, "R11 cfg after reset", 32'(rd), 32'd0);
    regRead(8'h40, rd); check(rd == 8'h00, "R11 unmapped reads zero", 32'(rd), 32'd0);
    idleCycles(3, "R11 R1 passthrough after reset");

    // R8: configuration byte read/write
    regWrite(8'h0E, 8'hA4);
    regRead(8'h0E, rd); check(rd == 8'hA4, "R8 cfg readback", 32'(rd), 32'hA4);

    runTest(2'b01, 1'b0, 1'b0, "A-only restart");

    // R5 R7: signature read-only and stable while done
    regWrite(8'h24, 8'hFF);
    regWrite(8'h25, 8'hEE);
    idleCycles(4, "R1 passthrough while done");
    #2 check(bistDone == 1'b1, "R7 done holds", 32'(bistDone), 32'd1);
    checkSig("R5 R7 signature unchanged by writes");

    // R10: empty selection start ignored
    @(negedge clk); startPulse = 1'b1; chanSel = 2'b00;
    @(negedge clk); startPulse = 1'b0;
    idleCycles(3, "R10 passthrough after empty start");
    #2 check(bistDone == 1'b1, "R10 done kept", 32'(bistDone), 32'd1);
    checkSig("R10 signature kept");

    // R8 continue mode, B only, gapped valid, mid-run start (R9)
    regWrite(8'h0E, 8'h00);
    runTest(2'b10, 1'b1, 1'b1, "B-only continue R8 R9");

    runTest(2'b11, 1'b0, 1'b1, "both continue R6 R9");

    regWrite(8'h0E, 8'h04);
    runTest(2'b11, 1'b1, 1'b0, "both restart R8");

    idleCycles(2, "R1 passthrough at end");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule